// File: doc/BRIEF.md
# Digital Correlation Segment LCD Waveform Generator

This block produces the logic-level drive for the common (COM) and segment (SEG) terminals of a multiplexed segment LCD without generating any intermediate bias voltage. Each pixel is switched on or off purely by the phase of its SEG signal relative to its COM signal. The COM being addressed in a sub-frame toggles at the base rate. The other COMs toggle at twice that rate, so they decorrelate from every SEG.

A timing generator outside the block supplies two single-cycle enables: a sub-frame strobe and a base-phase step. Inside each sub-frame a two-bit phase counter restarts on the strobe and advances on each phase step. Bit 1 of this counter is the base-rate square wave and bit 0 is the double-rate wave. A frame spans M sub-frames for waveform A, or 2M sub-frames for waveform B, where the second half of a type B frame repeats the first half with the addressed COM inverted.

The pixel array, the common count and the waveform type are copied into shadow state only at frame boundaries, or continuously while the block is disabled. This keeps each frame self-consistent. A live invert control produces a negative image.

Top module: `lcd_corr_drv`

## Requirements
- R1: The programmed count field `com_count` holds M-1 (M from 1 to MAX_COMS). With `wave_sel`=0 (type A) a frame has M sub-frames, each sub-frame strobe advances the sub-frame index, the index wraps to 0 after M-1, and COM i is the addressed COM in sub-frame i.
- R2: With `wave_sel`=1 (type B) a frame has 2M sub-frames. COM i is addressed in sub-frames i and M+i, and its level in sub-frame M+i is the complement of its level in sub-frame i at the same phase.
- R3: A sub-frame strobe clears the phase counter, and a phase step without a strobe increments it modulo 4. The addressed COM outputs bit 1 of the counter (inverted in the second half of a type B frame).
- R4: Every COM below M that is not addressed outputs bit 0 of the phase counter, which is twice the base rate.
- R5: SEG s outputs the addressed COM's level XOR pixel bit (s*MAX_COMS + c) XOR `invert`, where c is the addressed COM. An on pixel (bit 1) is therefore driven in antiphase and an off pixel in phase.
- R6: Raising `invert` complements every SEG output in the same cycle without changing any COM.
- R7: COMs numbered M and above stay low while enabled.
- R8: The pixel array, the count and the waveform type are sampled only by a strobe in the last sub-frame of a frame, or on any cycle while disabled. Changes at other times have no effect until the next frame.
- R9: While `enable` is low, every COM and SEG output is low and the sequencer is held at sub-frame 0 with phase 0. Reset gives the same output state.
- R10: Over a whole frame with four equal-length phase steps per sub-frame, each SEG spends as many cycles above its COM (COM below M) as below it, so there is zero net DC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Block enable; low forces outputs low and reloads shadow state |
| sf_stb | input | 1 | Sub-frame strobe from the timing generator |
| phase_en | input | 1 | Base-phase step enable from the timing generator |
| com_count | input | $clog2(MAX_COMS) | Number of active commons minus one |
| wave_sel | input | 1 | 0 = type A waveform, 1 = type B waveform |
| invert | input | 1 | Complement all pixel states (negative image) |
| pix_bits | input | MAX_COMS*NUM_SEGS | Pixel array, bit s*MAX_COMS+c = SEG s at COM c |
| com_o | output | MAX_COMS | Common terminal levels |
| seg_o | output | NUM_SEGS | Segment terminal levels |

## Verification
The bench builds the block with MAX_COMS=8 and NUM_SEGS=4. Eight commons allow the full 16-sub-frame type B frame, which exercises the widest sub-frame index and its wrap. Four segments keep the pixel array small enough that distinct patterns can be chosen for each COM.

The bench runs frames with M of 1, 3, 4 and 8 under both waveform types and with invert set and cleared. It changes the pixel array mid-frame to check the boundary sampling. It also integrates COM minus SEG over aligned frames to confirm there is no net DC.

// File: rtl/lcd_corr_pkg.sv
// Package: shared types and helpers for the digital correlation LCD driver.
// Assumes the phase counter is two bits wide (base wave on bit 1, double rate on bit 0).
package lcd_corr_pkg;

    typedef enum logic {
        WAVE_A = 1'b0,
        WAVE_B = 1'b1
    } wave_e;

    localparam int unsigned PHASE_W = 2;

    typedef logic [PHASE_W-1:0] phase_t;

    // Index width needed to count 2*n sub-frames of a type B frame.
    function automatic int unsigned sf_index_width(input int unsigned n);
        return ((n > 1) ? $clog2(n) : 1) + 1;
    endfunction

endpackage

// File: rtl/lcd_corr_seq.sv
// Sequencer: keeps the sub-frame index and the phase counter, and latches the
// common count and waveform type at frame boundaries. It derives the addressed
// COM and whether the second, inverted half of a type B frame is running.
// Assumes sf_stb has priority over phase_en when both are high.
module lcd_corr_seq
    import lcd_corr_pkg::*;
#(
    parameter int unsigned MAX_COMS = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     enable,
    input  logic                     sf_stb,
    input  logic                     phase_en,
    input  logic [(MAX_COMS>1 ? $clog2(MAX_COMS) : 1)-1:0] com_count,
    input  logic                     wave_sel,
    output logic [sf_index_width(MAX_COMS)-1:0] sf_idx,
    output phase_t                   ph_q,
    output logic [sf_index_width(MAX_COMS)-1:0] cfg_m,
    output logic                     cfg_b,
    output logic [(MAX_COMS>1 ? $clog2(MAX_COMS) : 1)-1:0] act_com,
    output logic                     second_half,
    output logic                     frame_wrap
);
    localparam int unsigned CW = (MAX_COMS > 1) ? $clog2(MAX_COMS) : 1;
    localparam int unsigned IW = sf_index_width(MAX_COMS);
    localparam int unsigned LW = IW + 1;

    logic [IW-1:0] idx_q;
    phase_t        phase_q;
    logic [IW-1:0] m_q;
    wave_e         type_q;
    logic [IW-1:0] m_next;
    logic [LW-1:0] frame_len;
    logic [LW-1:0] last_w;
    logic [IW-1:0] rel_idx;

    // Decode the next common count from the programmed field.
    always_comb m_next = {{(IW-CW){1'b0}}, com_count} + IW'(1);

    // Frame length and index of its last sub-frame.
    always_comb begin
        frame_len = (type_q == WAVE_B) ? {m_q, 1'b0} : {1'b0, m_q};
        last_w    = frame_len - LW'(1);
    end

    // Frame boundary: a strobe arriving in the last sub-frame.
    always_comb frame_wrap = enable && sf_stb && (idx_q == last_w[IW-1:0]);

    // Sub-frame index, phase counter and frame-level configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            phase_q <= '0;
            m_q     <= IW'(1);
            type_q  <= WAVE_A;
        end else if (!enable) begin
            idx_q   <= '0;
            phase_q <= '0;
            m_q     <= m_next;
            type_q  <= wave_e'(wave_sel);
        end else if (sf_stb) begin
            phase_q <= '0;
            if (frame_wrap) begin
                idx_q  <= '0;
                m_q    <= m_next;
                type_q <= wave_e'(wave_sel);
            end else begin
                idx_q  <= idx_q + IW'(1);
            end
        end else if (phase_en) begin
            phase_q <= phase_q + phase_t'(1);
        end
    end

    // Addressed COM and frame half.
    always_comb begin
        second_half = (type_q == WAVE_B) && (idx_q >= m_q);
        rel_idx     = second_half ? (idx_q - m_q) : idx_q;
        act_com     = rel_idx[CW-1:0];
    end

    assign sf_idx = idx_q;
    assign ph_q   = phase_q;
    assign cfg_m  = m_q;
    assign cfg_b  = (type_q == WAVE_B);

endmodule

// File: rtl/lcd_corr_fbuf.sv
// Frame buffer shadow: holds the pixel array used for the current frame.
// Assumes frame_wrap is a single-cycle pulse at the end of the last sub-frame.
module lcd_corr_fbuf #(
    parameter int unsigned FBW = 64
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           enable,
    input  logic           frame_wrap,
    input  logic [FBW-1:0] pix_in,
    output logic [FBW-1:0] shadow
);
    // Reload at frame boundary or continuously while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= '0;
        end else if (!enable || frame_wrap) begin
            shadow <= pix_in;
        end
    end
endmodule

// File: rtl/lcd_corr_com.sv
// COM drivers: the addressed COM follows the base wave (inverted in the second
// half of a type B frame); other active COMs follow the double-rate wave;
// COMs at or beyond the programmed count stay low. Outputs are combinational
// from sequencer registers.
module lcd_corr_com
    import lcd_corr_pkg::*;
#(
    parameter int unsigned MAX_COMS = 8
) (
    input  logic                 enable,
    input  phase_t               ph_q,
    input  logic                 second_half,
    input  logic [sf_index_width(MAX_COMS)-1:0] cfg_m,
    input  logic [(MAX_COMS>1 ? $clog2(MAX_COMS) : 1)-1:0] act_com,
    output logic                 act_level,
    output logic [MAX_COMS-1:0]  com_o
);
    localparam int unsigned CW = (MAX_COMS > 1) ? $clog2(MAX_COMS) : 1;
    localparam int unsigned IW = sf_index_width(MAX_COMS);

    // Level of the addressed COM in this phase.
    always_comb act_level = ph_q[1] ^ second_half;

    for (genvar c = 0; c < MAX_COMS; c++) begin : g_com
        // Per-terminal level selection.
        always_comb begin
            if (!enable || (IW'(c) >= cfg_m)) begin
                com_o[c] = 1'b0;
            end else if (CW'(c) == act_com) begin
                com_o[c] = act_level;
            end else begin
                com_o[c] = ph_q[0];
            end
        end
    end
endmodule

// File: rtl/lcd_corr_seg.sv
// SEG drivers: each segment is the addressed COM level XOR its pixel bit for
// that COM XOR the global invert, so lit pixels run in antiphase.
// Assumes pixel bit s*MAX_COMS+c belongs to SEG s at COM c.
module lcd_corr_seg #(
    parameter int unsigned MAX_COMS = 8,
    parameter int unsigned NUM_SEGS = 8
) (
    input  logic                            enable,
    input  logic                            invert,
    input  logic                            act_level,
    input  logic [(MAX_COMS>1 ? $clog2(MAX_COMS) : 1)-1:0] act_com,
    input  logic [NUM_SEGS*MAX_COMS-1:0]    shadow,
    output logic [NUM_SEGS-1:0]             seg_o
);
    for (genvar s = 0; s < NUM_SEGS; s++) begin : g_seg
        logic [MAX_COMS-1:0] col;
        // Pixel row for this segment.
        always_comb col = shadow[s*MAX_COMS +: MAX_COMS];
        // Correlation output for this segment.
        always_comb seg_o[s] = enable && (act_level ^ col[act_com] ^ invert);
    end
endmodule

// File: rtl/lcd_corr_drv.sv
// Top: digital correlation segment LCD waveform generator.
// Wires the sequencer, frame shadow, COM and SEG drivers together.
// Assumes sf_stb and phase_en come from an external timing generator.
module lcd_corr_drv
    import lcd_corr_pkg::*;
#(
    parameter int unsigned MAX_COMS = 8,
    parameter int unsigned NUM_SEGS = 8
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          enable,
    input  logic                                          sf_stb,
    input  logic                                          phase_en,
    input  logic [(MAX_COMS>1 ? $clog2(MAX_COMS) : 1)-1:0] com_count,
    input  logic                                          wave_sel,
    input  logic                                          invert,
    input  logic [MAX_COMS*NUM_SEGS-1:0]                  pix_bits,
    output logic [MAX_COMS-1:0]                           com_o,
    output logic [NUM_SEGS-1:0]                           seg_o
);
    localparam int unsigned CW  = (MAX_COMS > 1) ? $clog2(MAX_COMS) : 1;
    localparam int unsigned IW  = sf_index_width(MAX_COMS);
    localparam int unsigned FBW = MAX_COMS * NUM_SEGS;

    logic [IW-1:0]  sf_idx;
    phase_t         ph_q;
    logic [IW-1:0]  cfg_m;
    logic           cfg_b;
    logic [CW-1:0]  act_com;
    logic           second_half;
    logic           frame_wrap;
    logic [FBW-1:0] shadow;
    logic           act_level;

    lcd_corr_seq #(.MAX_COMS(MAX_COMS)) u_seq (
        .clk(clk), .rst_n(rst_n), .enable(enable), .sf_stb(sf_stb),
        .phase_en(phase_en), .com_count(com_count), .wave_sel(wave_sel),
        .sf_idx(sf_idx), .ph_q(ph_q), .cfg_m(cfg_m), .cfg_b(cfg_b),
        .act_com(act_com), .second_half(second_half), .frame_wrap(frame_wrap)
    );

    lcd_corr_fbuf #(.FBW(FBW)) u_fbuf (
        .clk(clk), .rst_n(rst_n), .enable(enable), .frame_wrap(frame_wrap),
        .pix_in(pix_bits), .shadow(shadow)
    );

    lcd_corr_com #(.MAX_COMS(MAX_COMS)) u_com (
        .enable(enable), .ph_q(ph_q), .second_half(second_half),
        .cfg_m(cfg_m), .act_com(act_com), .act_level(act_level), .com_o(com_o)
    );

    lcd_corr_seg #(.MAX_COMS(MAX_COMS), .NUM_SEGS(NUM_SEGS)) u_seg (
        .enable(enable), .invert(invert), .act_level(act_level),
        .act_com(act_com), .shadow(shadow), .seg_o(seg_o)
    );

endmodule

// File: rtl/lcd_corr_chk.sv
// Checker: temporal properties of the LCD waveform generator, bound to the top.
module lcd_corr_chk
    import lcd_corr_pkg::*;
#(
    parameter int unsigned MAX_COMS = 8,
    parameter int unsigned NUM_SEGS = 8
) (
    input logic                                 clk,
    input logic                                 rst_n,
    input logic                                 enable,
    input logic                                 sf_stb,
    input logic                                 invert,
    input logic [sf_index_width(MAX_COMS)-1:0]  sf_idx,
    input phase_t                               ph_q,
    input logic [sf_index_width(MAX_COMS)-1:0]  cfg_m,
    input logic                                 cfg_b,
    input logic [(MAX_COMS>1 ? $clog2(MAX_COMS) : 1)-1:0] act_com,
    input logic                                 frame_wrap,
    input logic [MAX_COMS*NUM_SEGS-1:0]         shadow,
    input logic [MAX_COMS-1:0]                  com_o,
    input logic [NUM_SEGS-1:0]                  seg_o
);
    localparam int unsigned IW = sf_index_width(MAX_COMS);

    // R9: idle outputs are all low.
    assert_idle_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (com_o == '0) && (seg_o == '0));

    // R1, R2: index stays inside the frame length.
    assert_idx_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        enable |-> ({1'b0, sf_idx} < (cfg_b ? {cfg_m, 1'b0} : {1'b0, cfg_m})));

    // R3: a strobe restarts the phase.
    assert_phase_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sf_stb) && $past(enable) |-> (ph_q == '0));

    // R8: shadow changes only after a frame boundary.
    assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        enable && $past(enable) && !$past(frame_wrap) |-> $stable(shadow));

    // R7: commons at or above the programmed count are low.
    assert_unused_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        enable |-> ((com_o >> cfg_m) == '0));

    for (genvar s = 0; s < NUM_SEGS; s++) begin : g_seg_chk
        logic [MAX_COMS-1:0] col;
        always_comb col = shadow[s*MAX_COMS +: MAX_COMS];
        // R5: segment correlates with the addressed common.
        assert_corr_R5: assert property (@(posedge clk) disable iff (!rst_n)
            enable |-> (seg_o[s] == (com_o[act_com] ^ col[act_com] ^ invert)));
    end

    logic unused_ok;
    always_comb unused_ok = ^{ph_q, IW'(0)};

endmodule

bind lcd_corr_drv lcd_corr_chk #(.MAX_COMS(MAX_COMS), .NUM_SEGS(NUM_SEGS)) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sf_stb(sf_stb), .invert(invert),
    .sf_idx(sf_idx), .ph_q(ph_q), .cfg_m(cfg_m), .cfg_b(cfg_b),
    .act_com(act_com), .frame_wrap(frame_wrap), .shadow(shadow),
    .com_o(com_o), .seg_o(seg_o)
);

// File: tb/lcd_corr_drv_tb.sv
// Scoreboard bench for lcd_corr_drv: a driver task models the expected
// outputs from the requirements and queues them; a monitor compares.
module lcd_corr_drv_tb;
    localparam int NC = 8;
    localparam int NS = 4;

    typedef struct {
        logic [NC-1:0] com;
        logic [NS-1:0] seg;
        string         tag;
        bit            dc;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic          sf_stb = 1'b0;
    logic          phase_en = 1'b0;
    logic [2:0]    com_count = 3'd0;
    logic          wave_sel = 1'b0;
    logic          invert = 1'b0;
    logic [NC*NS-1:0] pix_bits = '0;
    logic [NC-1:0] com_o;
    logic [NS-1:0] seg_o;

    int total = 0;
    int bad = 0;
    exp_t q[$];
    int dc_acc[NC][NS];

    // model state
    int          mq = 0;
    int          midx = 0;
    int          mm = 1;
    bit          mb = 0;
    logic [NC*NS-1:0] msh = '0;

    always #4 clk = ~clk;

    lcd_corr_drv #(.MAX_COMS(NC), .NUM_SEGS(NS)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .sf_stb(sf_stb),
        .phase_en(phase_en), .com_count(com_count), .wave_sel(wave_sel),
        .invert(invert), .pix_bits(pix_bits), .com_o(com_o), .seg_o(seg_o)
    );

    task automatic check(input bit ok, input string tag, input string act, input string expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%s expected=%s", tag, act, expv);
        end
    endtask

    // Drive one cycle's inputs, advance the model, queue the expected outputs.
    task automatic step(input logic s, input logic p, input string tag, input bit dc = 0);
        exp_t e;
        bit half;
        int a;
        sf_stb = s;
        phase_en = p;
        if (!enable) begin
            mq = 0; midx = 0; mm = int'(com_count) + 1; mb = wave_sel; msh = pix_bits;
        end else if (s) begin
            mq = 0;
            if (midx == (mb ? 2*mm - 1 : mm - 1)) begin
                midx = 0; msh = pix_bits; mm = int'(com_count) + 1; mb = wave_sel;
            end else midx++;
        end else if (p) begin
            mq = (mq + 1) % 4;
        end
        half = mb && (midx >= mm);
        a = half ? midx - mm : midx;
        for (int c = 0; c < NC; c++) begin
            if (!enable || c >= mm) e.com[c] = 1'b0;
            else if (c == a) e.com[c] = mq[1] ^ half;
            else e.com[c] = mq[0];
        end
        for (int si = 0; si < NS; si++)
            e.seg[si] = enable && ((mq[1] ^ half) ^ msh[si*NC + a] ^ invert);
        e.tag = tag;
        e.dc = dc;
        q.push_back(e);
        @(negedge clk);
    endtask

    // One sub-frame: strobe then three phase steps.
    task automatic run_sf(input int n, input string tag, input bit dc = 0);
        for (int i = 0; i < n; i++) begin
            step(1'b1, 1'b0, tag, dc);
            for (int k = 0; k < 3; k++) step(1'b0, 1'b1, tag, dc);
        end
    endtask

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
    endtask

    task automatic dc_clear();
        for (int c = 0; c < NC; c++)
            for (int s = 0; s < NS; s++) dc_acc[c][s] = 0;
    endtask

    task automatic dc_check(input int m);
        drain();
        for (int c = 0; c < m; c++)
            for (int s = 0; s < NS; s++)
                check(dc_acc[c][s] == 0, $sformatf("R10 dc com%0d seg%0d", c, s),
                      $sformatf("%0d", dc_acc[c][s]), "0");
    endtask

    // Monitor: compare after each edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() != 0) begin
                exp_t e;
                e = q.pop_front();
                check((com_o === e.com) && (seg_o === e.seg), e.tag,
                      $sformatf("com=%b seg=%b", com_o, seg_o),
                      $sformatf("com=%b seg=%b", e.com, e.seg));
                if (e.dc)
                    for (int c = 0; c < NC; c++)
                        for (int s = 0; s < NS; s++)
                            dc_acc[c][s] += int'(com_o[c]) - int'(seg_o[s]);
            end
        end
    end

    // Watchdog.
    initial begin
        #1000000;
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        dc_clear();
        repeat (3) @(negedge clk);
        check((com_o == '0) && (seg_o == '0), "R9 reset",
              $sformatf("%b/%b", com_o, seg_o), "0/0");
        rst_n = 1'b1;
        // R9: disabled.
        com_count = 3'd3; wave_sel = 1'b0; pix_bits = 32'hA5C3_1E69;
        step(1'b1, 1'b1, "R9 idle");
        step(1'b0, 1'b1, "R9 idle");
        // R1 R3 R4 R5: type A, M=4.
        enable = 1'b1;
        run_sf(8, "R1 R3 R4 R5 typeA");
        // R8: change pixels and count mid-frame.
        run_sf(1, "R8 pre");
        pix_bits = 32'h0F0F_F0F0; com_count = 3'd1;
        run_sf(3, "R8 old frame");
        run_sf(6, "R8 new frame");
        // R6: invert toggle.
        invert = 1'b1;
        run_sf(4, "R6 invert");
        invert = 1'b0;
        // R2 R10: type B, M=3, DC over aligned frame.
        enable = 1'b0; com_count = 3'd2; wave_sel = 1'b1; pix_bits = 32'h3C96_5AE1;
        step(1'b0, 1'b0, "R9 reload");
        enable = 1'b1;
        run_sf(5, "R2 typeB warm");
        drain(); dc_clear();
        run_sf(6, "R2 R10 typeB", 1'b1);
        dc_check(3);
        // R1 R7 R10: M=1 type A.
        enable = 1'b0; com_count = 3'd0; wave_sel = 1'b0; pix_bits = 32'h0101_0001;
        step(1'b0, 1'b0, "R9 reload");
        enable = 1'b1;
        drain(); dc_clear();
        run_sf(2, "R1 R7 M1", 1'b1);
        dc_check(1);
        // R2 R6 R10: M=8 type B inverted.
        enable = 1'b0; com_count = 3'd7; wave_sel = 1'b1; invert = 1'b1;
        pix_bits = 32'hDEAD_BEEF;
        step(1'b0, 1'b0, "R9 reload");
        enable = 1'b1;
        run_sf(15, "R2 R6 M8 warm");
        drain(); dc_clear();
        run_sf(16, "R2 R6 R10 M8", 1'b1);
        dc_check(8);
        // R9: disable mid-frame.
        run_sf(3, "R2 run");
        enable = 1'b0;
        step(1'b1, 1'b1, "R9 disabled");
        step(1'b0, 1'b1, "R9 disabled");
        drain();
        check((com_o == '0) && (seg_o == '0), "R9 final",
              $sformatf("%b/%b", com_o, seg_o), "0/0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule